// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block translates 32-bit virtual addresses into physical addresses through a small fully associative table of page mappings. Each mapping records a virtual page number, an address-space tag, a physical frame number and a few control bits. Because the tag takes part in every comparison, mappings of several processes stay resident together. The same virtual address seen under two tags can reach two different frames. Two mappings under different tags may also name one frame, which lets processes share memory.

A lookup presents a virtual address, the current address-space tag, a privilege flag and a load/store flag. One cycle later the block returns a registered result code and physical address. Pages are 4 KB, so the low 12 address bits pass through unchanged. User-mode accesses to the upper half of the address space are trapped as address errors before any table search. Software fills the table through an indexed write port. There is no page-table walk and no replacement logic.

Top module: `tlbc_top`

## Requirements
- R1: After reset every entry is invalid, `rsp_valid` is 0, `rsp_code` is 1 (miss) and `rsp_paddr` is 0, so any lookup issued after reset misses.
- R2: `rsp_valid` is high exactly in the cycle after a cycle with `lk_valid` high. While `rsp_valid` is low, `rsp_code` and `rsp_paddr` hold their values.
- R3: A lookup hits when an entry is valid, its page number equals `lk_vaddr[31:12]`, and its tag equals `lk_asid` or its global bit is set. A hit returns code 0 and `rsp_paddr = {pfn, lk_vaddr[11:0]}`. Entries with different tags may map one frame.
- R4: When no entry matches, including when only the tag differs on a non-global entry, the code is 1 (miss) and `rsp_paddr` is 0.
- R5: An entry with its global bit set matches under any `lk_asid`.
- R6: With `lk_kernel` low and `lk_vaddr[31]` set, the code is 2 (address error) and `rsp_paddr` is 0, whatever the table holds. With `lk_kernel` high, the same address is translated normally.
- R7: A store (`lk_store` high) that hits an entry whose dirty bit is clear returns code 3 (modify fault) with `rsp_paddr` 0. A store to a dirty entry, or any load, returns the hit.
- R8: A write with `wr_en` high replaces entry `wr_index` with the presented fields. A lookup issued in the same cycle sees the old contents, and lookups from the next cycle see the new ones. Writes with `wr_index` of 48 or more are ignored.
- R9: When several entries match, the lowest-numbered one supplies the frame and dirty bit.
- R10: Writing an entry with `wr_valid` low removes it from all later matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address-space tag |
| lk_kernel | input | 1 | Privileged access |
| lk_store | input | 1 | Access is a store |
| wr_en | input | 1 | Write one table entry |
| wr_index | input | 6 | Entry number to write |
| wr_vpn | input | 20 | Virtual page number of the new entry |
| wr_asid | input | 8 | Tag of the new entry |
| wr_global | input | 1 | New entry matches any tag |
| wr_valid | input | 1 | New entry is valid |
| wr_dirty | input | 1 | New entry permits stores |
| wr_pfn | input | 20 | Physical frame number of the new entry |
| rsp_valid | output | 1 | Result present |
| rsp_code | output | 2 | 0 hit, 1 miss, 2 address error, 3 modify fault |
| rsp_paddr | output | 32 | Translated address, 0 unless hit |

## Verification
The assertions take the inputs to be known, non-X values whenever reset is released. They also assume the write and lookup ports may be active in the same cycle, and the same-cycle ordering claim in R8 rests on that. The stimulus drives every input to a defined value at each falling edge. It keeps page numbers and tags in a narrow pool, so random lookups hit, miss, trip the upper-half trap and meet duplicate entries often. Directed steps cover the last entry, an out-of-range index and a write overlapping a lookup.

// File: rtl/tlbc_pkg.sv
// Shared widths, result codes and entry layout for the translation buffer.
// Assumes 32-bit virtual addresses and 4 KB pages.
package tlbc_pkg;
    parameter int VA_W      = 32;
    parameter int PAGE_BITS = 12;
    parameter int ASID_W    = 8;
    parameter int PFN_W     = 20;
    parameter int VPN_W     = VA_W - PAGE_BITS;
    parameter int PA_W      = PFN_W + PAGE_BITS;

    typedef enum logic [1:0] {
        XL_HIT       = 2'd0,
        XL_MISS      = 2'd1,
        XL_ADDR_ERR  = 2'd2,
        XL_MOD_FAULT = 2'd3
    } xlate_code_e;

    typedef struct packed {
        logic              valid;
        logic              global;
        logic              dirty;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PFN_W-1:0]  pfn;
    } tlb_entry_t;
endpackage

// File: rtl/tlbc_entry_store.sv
// Register file of translation entries, written one at a time by index.
// Assumes indices at or above NUM_ENTRIES are to be ignored.
module tlbc_entry_store
    import tlbc_pkg::*;
#(
    parameter int NUM_ENTRIES = 48,
    parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_index,
    input  tlb_entry_t            wr_entry,
    output tlb_entry_t            entries_o [NUM_ENTRIES]
);
    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
        tlb_entry_t entry_q;
        logic       sel;

        assign sel = wr_en && (wr_index == IDX_W'(i));

        // Hold one entry; clear its valid bit on reset, load it when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry_q <= '0;
            end else if (sel) begin
                entry_q <= wr_entry;
            end
        end

        assign entries_o[i] = entry_q;

        assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_index == IDX_W'(i)) |=> (entries_o[i] == $past(wr_entry)));
    end
endmodule

// File: rtl/tlbc_match.sv
// Compares a lookup page number and tag against every entry in parallel and
// picks the lowest-numbered match. Purely combinational apart from its check.
module tlbc_match
    import tlbc_pkg::*;
#(
    parameter int NUM_ENTRIES = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tlb_entry_t        entries_i [NUM_ENTRIES],
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              hit_o,
    output logic [PFN_W-1:0]  pfn_o,
    output logic              dirty_o
);
    logic [NUM_ENTRIES-1:0] raw_match;
    logic [NUM_ENTRIES-1:0] sel_oh;

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_cmp
        assign raw_match[i] = entries_i[i].valid
                            && (entries_i[i].vpn == lk_vpn)
                            && (entries_i[i].global || (entries_i[i].asid == lk_asid));
    end

    // Keep only the lowest-numbered matching entry.
    always_comb begin
        logic found;
        found  = 1'b0;
        sel_oh = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (raw_match[i] && !found) begin
                sel_oh[i] = 1'b1;
                found     = 1'b1;
            end
        end
    end

    // Gather frame and dirty bit of the selected entry.
    always_comb begin
        pfn_o   = '0;
        dirty_o = 1'b0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (sel_oh[i]) begin
                pfn_o   = pfn_o | entries_i[i].pfn;
                dirty_o = dirty_o | entries_i[i].dirty;
            end
        end
    end

    assign hit_o = |raw_match;

    assert_sel_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_oh) && (hit_o == (sel_oh != '0)));
endmodule

// File: rtl/tlbc_resp.sv
// Resolves the result code for a lookup (privilege trap, miss, modify fault,
// hit) and registers it with the physical address one cycle after the request.
module tlbc_resp
    import tlbc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic             lk_kernel,
    input  logic             lk_store,
    input  logic             hit_i,
    input  logic [PFN_W-1:0] pfn_i,
    input  logic             dirty_i,
    output logic             rsp_valid,
    output logic [1:0]       rsp_code,
    output logic [PA_W-1:0]  rsp_paddr
);
    xlate_code_e      code_d;
    logic [PA_W-1:0]  paddr_d;
    logic             user_trap;

    assign user_trap = !lk_kernel && lk_vaddr[VA_W-1];

    // Decide the outcome, the privilege trap taking precedence over the search.
    always_comb begin
        paddr_d = '0;
        if (user_trap) begin
            code_d = XL_ADDR_ERR;
        end else if (!hit_i) begin
            code_d = XL_MISS;
        end else if (lk_store && !dirty_i) begin
            code_d = XL_MOD_FAULT;
        end else begin
            code_d  = XL_HIT;
            paddr_d = {pfn_i, lk_vaddr[PAGE_BITS-1:0]};
        end
    end

    // Register the result; hold code and address between requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_code  <= XL_MISS;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= lk_valid;
            if (lk_valid) begin
                rsp_code  <= code_d;
                rsp_paddr <= paddr_d;
            end
        end
    end

    assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!rsp_valid && $stable(rsp_code) && $stable(rsp_paddr)));
    assert_user_upper_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_kernel && lk_vaddr[VA_W-1])
            |=> (rsp_code == XL_ADDR_ERR && rsp_paddr == '0));
    assert_offset_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (rsp_code != XL_HIT
                      || rsp_paddr[PAGE_BITS-1:0] == $past(lk_vaddr[PAGE_BITS-1:0])));
    assert_clean_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_store && hit_i && !dirty_i && lk_kernel)
            |=> (rsp_code == XL_MOD_FAULT && rsp_paddr == '0));
endmodule

// File: rtl/tlbc_top.sv
// Fully associative, tag-qualified translation buffer. Lookups are answered
// one cycle later; table writes are visible to lookups from the next cycle.
module tlbc_top
    import tlbc_pkg::*;
#(
    parameter int NUM_ENTRIES = 48,
    parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_kernel,
    input  logic              lk_store,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_index,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_global,
    input  logic              wr_valid,
    input  logic              wr_dirty,
    input  logic [PFN_W-1:0]  wr_pfn,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic [PA_W-1:0]   rsp_paddr
);
    tlb_entry_t       wr_entry;
    tlb_entry_t       entries [NUM_ENTRIES];
    logic             hit;
    logic [PFN_W-1:0] sel_pfn;
    logic             sel_dirty;

    // Pack the write-port fields into one entry.
    always_comb begin
        wr_entry.valid  = wr_valid;
        wr_entry.global = wr_global;
        wr_entry.dirty  = wr_dirty;
        wr_entry.asid   = wr_asid;
        wr_entry.vpn    = wr_vpn;
        wr_entry.pfn    = wr_pfn;
    end

    tlbc_entry_store #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_index(wr_index),
        .wr_entry(wr_entry), .entries_o(entries)
    );

    tlbc_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_match (
        .clk(clk), .rst_n(rst_n), .entries_i(entries),
        .lk_vpn(lk_vaddr[VA_W-1:PAGE_BITS]), .lk_asid(lk_asid),
        .hit_o(hit), .pfn_o(sel_pfn), .dirty_o(sel_dirty)
    );

    tlbc_resp u_resp (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_kernel(lk_kernel), .lk_store(lk_store), .hit_i(hit),
        .pfn_i(sel_pfn), .dirty_i(sel_dirty), .rsp_valid(rsp_valid),
        .rsp_code(rsp_code), .rsp_paddr(rsp_paddr)
    );
endmodule

// File: tb/test_tlbc_top.sv
module test_tlbc_top;
    localparam int ENTRIES = 48;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid, lk_kernel, lk_store;
    logic [31:0] lk_vaddr;
    logic [7:0]  lk_asid;
    logic        wr_en, wr_global, wr_valid, wr_dirty;
    logic [5:0]  wr_index;
    logic [19:0] wr_vpn, wr_pfn;
    logic [7:0]  wr_asid;
    logic        rsp_valid;
    logic [1:0]  rsp_code;
    logic [31:0] rsp_paddr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    bit        m_v [ENTRIES];
    bit        m_g [ENTRIES];
    bit        m_d [ENTRIES];
    bit [7:0]  m_a [ENTRIES];
    bit [19:0] m_vpn [ENTRIES];
    bit [19:0] m_pfn [ENTRIES];

    always #4 clk = ~clk;

    tlbc_top i_tlbc_top (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_asid(lk_asid), .lk_kernel(lk_kernel), .lk_store(lk_store),
        .wr_en(wr_en), .wr_index(wr_index), .wr_vpn(wr_vpn), .wr_asid(wr_asid),
        .wr_global(wr_global), .wr_valid(wr_valid), .wr_dirty(wr_dirty),
        .wr_pfn(wr_pfn), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .rsp_paddr(rsp_paddr)
    );

    function automatic void expect_xl(input bit [31:0] va, input bit [7:0] asid,
                                      input bit kern, input bit st,
                                      output bit [1:0] code, output bit [31:0] pa);
        int sel;
        sel  = -1;
        pa   = 32'h0;
        if (!kern && va[31]) begin
            code = 2'd2;
            return;
        end
        for (int i = 0; i < ENTRIES; i++) begin
            if (sel < 0 && m_v[i] && m_vpn[i] == va[31:12] && (m_g[i] || m_a[i] == asid))
                sel = i;
        end
        if (sel < 0) code = 2'd1;
        else if (st && !m_d[sel]) code = 2'd3;
        else begin
            code = 2'd0;
            pa   = {m_pfn[sel], va[11:0]};
        end
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input bit [63:0] act, input bit [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check the registered result one edge later.
    task automatic step(input bit w, input int widx, input bit [19:0] wvpn,
                        input bit [7:0] wasid, input bit wg, input bit wv, input bit wd,
                        input bit [19:0] wpfn, input bit l, input bit [31:0] va,
                        input bit [7:0] la, input bit kern, input bit st, input string req);
        bit [1:0]  ecode;
        bit [31:0] epa;
        bit [1:0]  prev_code;
        bit [31:0] prev_pa;
        prev_code = rsp_code;
        prev_pa   = rsp_paddr;
        wr_en = w; wr_index = 6'(widx); wr_vpn = wvpn; wr_asid = wasid;
        wr_global = wg; wr_valid = wv; wr_dirty = wd; wr_pfn = wpfn;
        lk_valid = l; lk_vaddr = va; lk_asid = la; lk_kernel = kern; lk_store = st;
        expect_xl(va, la, kern, st, ecode, epa);
        @(posedge clk);
        if (w && widx < ENTRIES) begin
            m_v[widx] = wv; m_g[widx] = wg; m_d[widx] = wd;
            m_a[widx] = wasid; m_vpn[widx] = wvpn; m_pfn[widx] = wpfn;
        end
        @(negedge clk);
        wr_en = 1'b0; lk_valid = 1'b0;
        check(rsp_valid == l, req, "rsp_valid", 64'(rsp_valid), 64'(l));
        if (l) begin
            check(rsp_code == ecode, req, "rsp_code", 64'(rsp_code), 64'(ecode));
            check(rsp_paddr == epa, req, "rsp_paddr", 64'(rsp_paddr), 64'(epa));
        end else begin
            check(rsp_code == prev_code && rsp_paddr == prev_pa, req, "held result",
                  {30'h0, rsp_code, rsp_paddr}, {30'h0, prev_code, prev_pa});
        end
    endtask

    task automatic wr(input int idx, input bit [19:0] vpn, input bit [7:0] asid,
                      input bit g, input bit v, input bit d, input bit [19:0] pfn,
                      input string req);
        step(1, idx, vpn, asid, g, v, d, pfn, 0, 32'h0, 8'h0, 0, 0, req);
    endtask

    task automatic lk(input bit [31:0] va, input bit [7:0] asid, input bit kern,
                      input bit st, input string req);
        step(0, 0, 20'h0, 8'h0, 0, 0, 0, 20'h0, 1, va, asid, kern, st, req);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < ENTRIES; i++) m_v[i] = 1'b0;
        rst_n = 1'b0;
        wr_en = 0; wr_index = 0; wr_vpn = 0; wr_asid = 0; wr_global = 0;
        wr_valid = 0; wr_dirty = 0; wr_pfn = 0;
        lk_valid = 0; lk_vaddr = 0; lk_asid = 0; lk_kernel = 0; lk_store = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
        check(rsp_code == 2'd1, "R1", "rsp_code after reset", 64'(rsp_code), 64'd1);
        check(rsp_paddr == 32'h0, "R1", "rsp_paddr after reset", 64'(rsp_paddr), 64'd0);
        lk(32'h0001_2345, 8'h05, 1, 0, "R1");

        // R3 basic hit; R4 tag mismatch; R3 sharing a frame across tags
        wr(0, 20'h00012, 8'h05, 0, 1, 1, 20'hABCDE, "R8");
        lk(32'h0001_2345, 8'h05, 0, 0, "R3");
        lk(32'h0001_2345, 8'h06, 0, 0, "R4");
        wr(1, 20'h00012, 8'h06, 0, 1, 1, 20'hABCDE, "R8");
        lk(32'h0001_2FFF, 8'h06, 0, 0, "R3");
        // R5 global entry at the last index
        wr(47, 20'h00777, 8'h09, 1, 1, 1, 20'h11111, "R8");
        lk(32'h0077_7ABC, 8'h33, 0, 0, "R5");
        // R6 upper-half trap for users, translation for kernel
        wr(2, 20'h80012, 8'h05, 1, 1, 1, 20'h22222, "R8");
        lk(32'h8001_2345, 8'h05, 0, 0, "R6");
        lk(32'h8001_2345, 8'h05, 1, 0, "R6");
        // R7 stores against dirty and clean entries
        lk(32'h0001_2010, 8'h05, 0, 1, "R7");
        wr(3, 20'h00444, 8'h05, 0, 1, 0, 20'h33333, "R8");
        lk(32'h0044_4004, 8'h05, 0, 0, "R7");
        lk(32'h0044_4004, 8'h05, 0, 1, "R7");
        // R8 write and lookup in one cycle, then next cycle
        step(1, 4, 20'h00555, 8'h05, 0, 1, 1, 20'h44444, 1, 32'h0055_5000, 8'h05, 0, 0, "R8");
        lk(32'h0055_5000, 8'h05, 0, 0, "R8");
        // R8 out-of-range index ignored
        wr(50, 20'h00666, 8'h00, 1, 1, 1, 20'h55555, "R8");
        lk(32'h0066_6000, 8'h00, 1, 0, "R8");
        // R9 duplicates; R10 invalidation
        wr(20, 20'h00999, 8'h00, 1, 1, 1, 20'h66666, "R9");
        wr(10, 20'h00999, 8'h00, 1, 1, 1, 20'h77777, "R9");
        lk(32'h0099_9123, 8'h01, 0, 0, "R9");
        wr(10, 20'h00999, 8'h00, 1, 0, 1, 20'h77777, "R10");
        lk(32'h0099_9123, 8'h01, 0, 0, "R10");
        // R2 idle cycle holds the result
        step(0, 0, 20'h0, 8'h0, 0, 0, 0, 20'h0, 0, 32'h0, 8'h0, 0, 0, "R2");

        // Random mix over a narrow pool of pages and tags
        for (int n = 0; n < 600; n++) begin
            bit        w, l, g, v, d, kern, st, hi;
            bit [19:0] vpn;
            bit [31:0] va;
            hi   = ($urandom % 4) == 0;
            vpn  = {hi, 16'h1234, 3'($urandom % 8)};
            w    = ($urandom % 3) == 0;
            l    = ($urandom % 4) != 0;
            g    = ($urandom % 6) == 0;
            v    = ($urandom % 8) != 0;
            d    = ($urandom % 2) == 0;
            kern = ($urandom % 2) == 0;
            st   = ($urandom % 3) == 0;
            va   = {1'(($urandom % 4) == 0), 16'h1234, 3'($urandom % 8), 12'($urandom)};
            step(w, int'($urandom % ENTRIES), vpn, 8'($urandom % 4), g, v, d,
                 20'($urandom), l, va, 8'($urandom % 4), kern, st, "R3");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule